// File: doc/BRIEF.md
# Single-Cycle Load-Store Processor Core

This block is a 32-bit processor core that completes each instruction in a single clock cycle. In every cycle it reads the instruction word at the program counter. It reads two source registers, runs the ALU, optionally reads or writes the internal data memory, and writes back one register. At the clock edge it moves to the next program counter. The core supports eight instructions:

- add, subtract, AND, OR and signed set-on-less-than, all in register format;
- load word;
- store word;
- branch-if-equal.

Both memories are internal word arrays. While reset is held, a simple load port fills them with a program and its initial data. After reset is released the core runs on its own. A commit trace on the outputs shows, for the instruction in the current cycle, its PC, its register write and its memory write.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and all 32 registers become 0. While `rst` is high, `rf_we_o` and `dm_we_o` stay low.
- R2: While `rst` is high and `ld_we` is high, `ld_data` is written at the rising edge into word `ld_addr`. With `ld_dmem`=0 the target is the instruction memory; with `ld_dmem`=1 it is the data memory. A load word from base register 0 then returns the preloaded words.
- R3: An instruction word has op in [31:26], rs in [25:21], rt in [20:16], rd in [15:11], an ignored shift field in [10:6] and funct in [5:0]. With op=0, funct 32 writes rs+rt and funct 34 writes rs-rt, both modulo 2^32, into register rd.
- R4: With op=0, funct 36 writes the bitwise AND of rs and rt into rd, and funct 37 writes the bitwise OR.
- R5: With op=0, funct 42 writes 1 into rd when rs is less than rt as signed 32-bit numbers, and 0 otherwise.
- R6: Register 0 always reads as 0. An instruction that targets register 0 leaves `rf_we_o` low and changes no state.
- R7: When an instruction writes a register it also reads, the operands are the values held before that cycle's edge. The new value is seen from the next instruction on.
- R8: Load word (op 35) forms the address R[rs] + sign-extended imm[15:0]. It writes data word number address[7:2] (with the default depth of 64 words) into register rt. The low two address bits are ignored.
- R9: Store word (op 43) forms the same address, raises `dm_we_o` and writes R[rt] into that data word. It writes no register.
- R10: Branch-if-equal (op 4) moves the PC to PC+4 + (sign-extended imm << 2) when R[rs] equals R[rt], and to PC+4 otherwise. This holds for negative offsets and for the extreme offsets 0x7FFF and 0x8000.
- R11: An unsupported opcode, or op 0 with an unsupported funct, writes neither a register nor memory and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; also enables the load port |
| ld_we | input | 1 | Load port write strobe (honoured only during reset) |
| ld_dmem | input | 1 | Load port target: 0 instruction memory, 1 data memory |
| ld_addr | input | LD_AW (7) | Load port word index |
| ld_data | input | 32 | Load port word |
| pc_o | output | 32 | PC of the instruction executing this cycle |
| instr_o | output | 32 | Instruction word executing this cycle |
| rf_we_o | output | 1 | A register is written at the next edge |
| rf_waddr_o | output | 5 | Register being written |
| rf_wdata_o | output | 32 | Value being written to the register |
| dm_we_o | output | 1 | A data word is written at the next edge |
| dm_addr_o | output | 32 | Byte address computed for load or store |
| dm_wdata_o | output | 32 | Store data (value of R[rt]) |

## Verification
Within one cycle, the register read of an instruction and its own write back to the same register can coincide. So can the branch compare and the next-PC update. The bench provokes the first case with operations such as `op r1, r1, r2` and with loops that increment a counter register in place. It judges each cycle's write value against an instruction-level model that uses the values from before the edge. The second case is provoked by loops that branch backwards and then fall through on equality, and by branches whose targets wrap the PC. Every cycle's `pc_o` is compared with the model's PC.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;

    localparam int XLEN = 32;

    localparam logic [5:0] OP_RTYPE = 6'd0;
    localparam logic [5:0] OP_BEQ   = 6'd4;
    localparam logic [5:0] OP_LOAD  = 6'd35;
    localparam logic [5:0] OP_STORE = 6'd43;

    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_AND = 6'd36;
    localparam logic [5:0] FN_OR  = 6'd37;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    typedef struct packed {
        logic    reg_write;
        logic    dst_rt;
        logic    alu_imm;
        logic    mem_to_reg;
        logic    mem_read;
        logic    mem_write;
        logic    branch;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
`timescale 1ns/1ps
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode_i,
    input  logic [5:0] funct_i,
    output ctrl_t      ctrl_o
);

    always_comb begin
        ctrl_o        = '0;
        ctrl_o.alu_op = ALU_ADD;
        case (opcode_i)
            OP_RTYPE: begin
                ctrl_o.reg_write = 1'b1;
                case (funct_i)
                    FN_ADD:  ctrl_o.alu_op = ALU_ADD;
                    FN_SUB:  ctrl_o.alu_op = ALU_SUB;
                    FN_AND:  ctrl_o.alu_op = ALU_AND;
                    FN_OR:   ctrl_o.alu_op = ALU_OR;
                    FN_SLT:  ctrl_o.alu_op = ALU_SLT;
                    default: ctrl_o.reg_write = 1'b0;
                endcase
            end
            OP_LOAD: begin
                ctrl_o.reg_write  = 1'b1;
                ctrl_o.dst_rt     = 1'b1;
                ctrl_o.alu_imm    = 1'b1;
                ctrl_o.mem_to_reg = 1'b1;
                ctrl_o.mem_read   = 1'b1;
            end
            OP_STORE: begin
                ctrl_o.alu_imm   = 1'b1;
                ctrl_o.mem_write = 1'b1;
            end
            OP_BEQ: begin
                ctrl_o.branch = 1'b1;
                ctrl_o.alu_op = ALU_SUB;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
    import sc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  alu_op_e       op_i,
    output logic [DW-1:0] res_o,
    output logic          zero_o
);

    always_comb begin
        case (op_i)
            ALU_SUB: res_o = a_i - b_i;
            ALU_AND: res_o = a_i & b_i;
            ALU_OR:  res_o = a_i | b_i;
            ALU_SLT: res_o = {{(DW-1){1'b0}}, $signed(a_i) < $signed(b_i)};
            default: res_o = a_i + b_i;
        endcase
    end

    assign zero_o = (res_o == '0);

endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile #(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a_i,
    input  logic [AW-1:0] ra_b_i,
    output logic [DW-1:0] rd_a_o,
    output logic [DW-1:0] rd_b_o,
    input  logic          we_i,
    input  logic [AW-1:0] wa_i,
    input  logic [DW-1:0] wd_i
);

    localparam int NREGS = 1 << AW;

    logic [DW-1:0] regs_d [NREGS];
    logic [DW-1:0] regs_q [NREGS];

    always_comb begin
        for (int i = 0; i < NREGS; i++) begin
            regs_d[i] = rst ? '0 : regs_q[i];
        end
        if (!rst && we_i && (wa_i != '0)) begin
            regs_d[wa_i] = wd_i;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREGS; i++) begin
            regs_q[i] <= regs_d[i];
        end
    end

    assign rd_a_o = (ra_a_i == '0) ? '0 : regs_q[ra_a_i];
    assign rd_b_o = (ra_b_i == '0) ? '0 : regs_q[ra_b_i];

    // R6
    r0_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ra_a_i == '0) |-> (rd_a_o == '0));

    // R7
    rf_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (we_i && wa_i != '0) |=> (regs_q[$past(wa_i)] == $past(wd_i)));

endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core
    import sc_pkg::*;
#(
    parameter  int IMEM_AW = 7,
    parameter  int DMEM_AW = 6,
    localparam int LD_AW   = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_we,
    input  logic             ld_dmem,
    input  logic [LD_AW-1:0] ld_addr,
    input  logic [31:0]      ld_data,
    output logic [31:0]      pc_o,
    output logic [31:0]      instr_o,
    output logic             rf_we_o,
    output logic [4:0]       rf_waddr_o,
    output logic [31:0]      rf_wdata_o,
    output logic             dm_we_o,
    output logic [31:0]      dm_addr_o,
    output logic [31:0]      dm_wdata_o
);

    localparam int IMEM_WORDS = 1 << IMEM_AW;
    localparam int DMEM_WORDS = 1 << DMEM_AW;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

    core_state_t st_d, st_q;

    logic [XLEN-1:0] imem_q [IMEM_WORDS];
    logic [XLEN-1:0] dmem_q [DMEM_WORDS];

    logic [XLEN-1:0]    instr;
    ctrl_t              ctrl;
    logic [XLEN-1:0]    rs_val, rt_val, imm_sext, alu_b, alu_res, mem_rdata;
    logic [XLEN-1:0]    pc_plus4, br_target;
    logic               alu_zero, take_br;
    logic [4:0]         waddr;
    logic [DMEM_AW-1:0] dmem_idx;

    assign instr    = imem_q[st_q.pc[IMEM_AW+1:2]];
    assign imm_sext = {{16{instr[15]}}, instr[15:0]};

    sc_decode i_decode (
        .opcode_i (instr[31:26]),
        .funct_i  (instr[5:0]),
        .ctrl_o   (ctrl)
    );

    sc_regfile #(.AW(5), .DW(XLEN)) i_regfile (
        .clk    (clk),
        .rst    (rst),
        .ra_a_i (instr[25:21]),
        .ra_b_i (instr[20:16]),
        .rd_a_o (rs_val),
        .rd_b_o (rt_val),
        .we_i   (rf_we_o),
        .wa_i   (waddr),
        .wd_i   (rf_wdata_o)
    );

    assign alu_b = ctrl.alu_imm ? imm_sext : rt_val;

    sc_alu #(.DW(XLEN)) i_alu (
        .a_i    (rs_val),
        .b_i    (alu_b),
        .op_i   (ctrl.alu_op),
        .res_o  (alu_res),
        .zero_o (alu_zero)
    );

    assign dmem_idx  = alu_res[DMEM_AW+1:2];
    assign mem_rdata = ctrl.mem_read ? dmem_q[dmem_idx] : '0;

    assign waddr      = ctrl.dst_rt ? instr[20:16] : instr[15:11];
    assign rf_wdata_o = ctrl.mem_to_reg ? mem_rdata : alu_res;
    assign rf_we_o    = ctrl.reg_write && !rst && (waddr != 5'd0);
    assign rf_waddr_o = waddr;

    assign dm_we_o    = ctrl.mem_write && !rst;
    assign dm_addr_o  = alu_res;
    assign dm_wdata_o = rt_val;

    assign pc_plus4  = st_q.pc + 32'd4;
    assign br_target = pc_plus4 + {imm_sext[29:0], 2'b00};
    assign take_br   = ctrl.branch && alu_zero;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.pc = '0;
        end else if (take_br) begin
            st_d.pc = br_target;
        end else begin
            st_d.pc = pc_plus4;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (rst && ld_we && !ld_dmem) begin
            imem_q[ld_addr[IMEM_AW-1:0]] <= ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst && ld_we && ld_dmem) begin
            dmem_q[ld_addr[DMEM_AW-1:0]] <= ld_data;
        end else if (dm_we_o) begin
            dmem_q[dmem_idx] <= rt_val;
        end
    end

    assign pc_o    = st_q.pc;
    assign instr_o = instr;

    // R1
    pc_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (st_q.pc == '0));

    // R10
    branch_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.branch && rs_val == rt_val) |=> (st_q.pc == $past(pc_plus4 + {imm_sext[29:0], 2'b00})));

    // R11
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.branch || rs_val != rt_val) |=> (st_q.pc == $past(st_q.pc) + 32'd4));

    // R9
    store_no_regwrite_chk: assert property (@(posedge clk) disable iff (rst)
        dm_we_o |-> (instr[31:26] == OP_STORE && !rf_we_o));

    // R11
    unsupported_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] != OP_RTYPE && instr[31:26] != OP_LOAD &&
         instr[31:26] != OP_STORE && instr[31:26] != OP_BEQ) |-> (!rf_we_o && !dm_we_o));

endmodule

// File: tb/test_sc_core.sv
`timescale 1ns/1ps
module test_sc_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_we = 1'b0;
    logic        ld_dmem = 1'b0;
    logic [6:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic [4:0]  rf_waddr_o;
    logic        rf_we_o, dm_we_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sc_core i_sc_core (
        .clk(clk), .rst(rst), .ld_we(ld_we), .ld_dmem(ld_dmem),
        .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o), .instr_o(instr_o),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
    );

    logic [31:0] prog  [128];
    logic [31:0] dinit [64];
    logic [31:0] m_reg [32];
    logic [31:0] m_dm  [64];
    logic [31:0] m_pc;

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, input int rt, input int rd);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic clear_prog();
        for (int i = 0; i < 128; i++) prog[i] = 32'd0;
    endtask

    task automatic set_data();
        for (int i = 0; i < 64; i++) dinit[i] = 32'h0100_0000 + 32'(i * 7);
        dinit[0] = 32'h0000_0000; dinit[1] = 32'h0000_0001;
        dinit[2] = 32'hFFFF_FFFF; dinit[3] = 32'h7FFF_FFFF;
        dinit[4] = 32'h8000_0000; dinit[5] = 32'h1234_5678;
        dinit[6] = 32'hA5A5_A5A5; dinit[7] = 32'h0000_0005;
    endtask

    // loads r1..r8 from data words 0..7 starting at prog index k
    task automatic put_loads(input int k);
        for (int r = 1; r <= 8; r++) prog[k + r - 1] = enc_i(6'd35, 0, r, 16'((r - 1) * 4));
    endtask

    task automatic check(input bit ok, input string tag, input string msg);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s", tag, msg);
        end
    endtask

    task automatic run_batch(input int ncyc);
        logic [31:0] ins, a, b, imm, e_wd, e_da, e_dd, e_npc, addr;
        logic [5:0]  op, fn;
        int          rs, rt, rd, e_wa;
        bit          e_we, e_dwe, ok;
        string       tag;
        rst = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 128; i++) begin
            ld_we = 1'b1; ld_dmem = 1'b0; ld_addr = 7'(i); ld_data = prog[i];
            @(negedge clk);
        end
        for (int i = 0; i < 64; i++) begin
            ld_we = 1'b1; ld_dmem = 1'b1; ld_addr = 7'(i); ld_data = dinit[i];
            @(negedge clk);
        end
        ld_we = 1'b0;
        #1;
        // R1: reset state visible at the ports
        check(pc_o == 32'd0 && !rf_we_o && !dm_we_o, "R1",
              $sformatf("reset pc=%h/00000000 rf_we=%b/0 dm_we=%b/0", pc_o, rf_we_o, dm_we_o));
        for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
        for (int i = 0; i < 64; i++) m_dm[i] = dinit[i];
        m_pc = 32'd0;
        @(negedge clk);
        rst = 1'b0;
        #1;
        for (int c = 0; c < ncyc; c++) begin
            ins = prog[m_pc[8:2]];
            op = ins[31:26]; fn = ins[5:0];
            rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
            a = m_reg[rs]; b = m_reg[rt];
            imm = {{16{ins[15]}}, ins[15:0]};
            e_we = 0; e_wa = 0; e_wd = '0; e_dwe = 0; e_da = '0; e_dd = '0;
            e_npc = m_pc + 32'd4;
            tag = "R11";
            addr = a + imm;
            if (op == 6'd0 && (fn == 6'd32 || fn == 6'd34 || fn == 6'd36 || fn == 6'd37 || fn == 6'd42)) begin
                case (fn)
                    6'd32: begin e_wd = a + b; tag = "R3"; end
                    6'd34: begin e_wd = a - b; tag = "R3"; end
                    6'd36: begin e_wd = a & b; tag = "R4"; end
                    6'd37: begin e_wd = a | b; tag = "R4"; end
                    default: begin e_wd = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R5"; end
                endcase
                e_wa = rd; e_we = (rd != 0);
                if (rd == 0) tag = "R6";
                else if (rd == rs || rd == rt) tag = "R7";
            end else if (op == 6'd35) begin
                e_wa = rt; e_we = (rt != 0); e_wd = m_dm[addr[7:2]];
                tag = (rt == 0) ? "R6" : ((rs == 0) ? "R2" : "R8");
            end else if (op == 6'd43) begin
                e_dwe = 1; e_da = addr; e_dd = b; tag = "R9";
            end else if (op == 6'd4) begin
                tag = "R10";
                if (a == b) e_npc = m_pc + 32'd4 + {imm[29:0], 2'b00};
            end
            ok = (pc_o == m_pc) && (rf_we_o == e_we) && (dm_we_o == e_dwe);
            if (e_we)  ok = ok && (rf_waddr_o == 5'(e_wa)) && (rf_wdata_o == e_wd);
            if (e_dwe) ok = ok && (dm_addr_o == e_da) && (dm_wdata_o == e_dd);
            check(ok, tag, $sformatf("pc=%h/%h rf_we=%b/%b wa=%0d/%0d wd=%h/%h dm_we=%b/%b da=%h/%h dd=%h/%h",
                  pc_o, m_pc, rf_we_o, e_we, rf_waddr_o, e_wa, rf_wdata_o, e_wd,
                  dm_we_o, e_dwe, dm_addr_o, e_da, dm_wdata_o, e_dd));
            if (e_we) m_reg[e_wa] = e_wd;
            if (e_dwe) m_dm[e_da[7:2]] = e_dd;
            m_pc = e_npc;
            @(negedge clk);
            #1;
        end
        rst = 1'b1;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [5:0] fns [5];
        int k;
        fns[0] = 6'd32; fns[1] = 6'd34; fns[2] = 6'd36; fns[3] = 6'd37; fns[4] = 6'd42;
        set_data();
        repeat (3) @(negedge clk);

        // R3 R4 R5 R6 R7: every register pair under each ALU function
        foreach (fns[f]) begin
            clear_prog();
            prog[0] = enc_r(6'd32, 1, 2, 9);   // registers read zero after reset
            put_loads(1);
            k = 9;
            for (int a = 1; a <= 8; a++) begin
                for (int b = 1; b <= 8; b++) begin
                    prog[k] = enc_r(fns[f], a, b, (a == b) ? 0 : 10 + ((a * 8 + b) % 20));
                    k++;
                end
            end
            prog[k] = enc_r(6'd32, 0, 0, 31);  // r0 still zero
            prog[k + 1] = enc_r(fns[f], 3, 5, 3);
            prog[k + 2] = enc_r(fns[f], 3, 3, 4);
            run_batch(k + 8);
        end

        // R8 R9: stores then loads through every base register and offset kind
        clear_prog();
        put_loads(0);
        k = 8;
        for (int bs = 1; bs <= 8; bs++) begin
            for (int o = 0; o < 3; o++) begin
                logic [15:0] off;
                off = (o == 0) ? 16'h0020 : ((o == 1) ? 16'hFFF0 : 16'h7FFC);
                prog[k]     = enc_i(6'd43, bs, 1 + ((bs + o) % 8), off);
                prog[k + 1] = enc_i(6'd35, bs, 20 + o, off);
                k += 2;
            end
        end
        prog[k] = enc_i(6'd35, 2, 0, 16'h0004);  // load into r0
        run_batch(k + 4);

        // R10 R11: taken, not taken, backward loop, extreme offsets, bad codes
        clear_prog();
        put_loads(0);
        prog[8]  = enc_i(6'd4, 1, 1, 16'd2);
        prog[9]  = enc_r(6'd32, 2, 2, 20);
        prog[10] = enc_r(6'd32, 2, 2, 21);
        prog[11] = enc_i(6'd4, 2, 3, 16'd5);
        prog[12] = enc_r(6'd32, 0, 0, 9);
        prog[13] = enc_r(6'd32, 9, 2, 9);
        prog[14] = enc_i(6'd4, 9, 8, 16'd1);
        prog[15] = enc_i(6'd4, 0, 0, 16'hFFFD);
        prog[16] = enc_i(6'd8, 1, 22, 16'd7);
        prog[17] = enc_r(6'd33, 2, 3, 23);
        prog[18] = enc_r(6'd0, 2, 3, 24);
        prog[19] = enc_i(6'd4, 3, 3, 16'h7FFF);
        prog[20] = enc_r(6'd32, 3, 4, 25);
        prog[21] = enc_i(6'd4, 0, 0, 16'h8000);
        prog[22] = enc_r(6'd34, 5, 6, 26);
        prog[23] = enc_i(6'd43, 0, 6, 16'h00FC);
        run_batch(50);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule